// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports whether the first is below, equal to, or above the second. Each of its three result outputs answers one of these cases, and exactly one of them is high. The operands are cut into 4-bit slices. Each slice is handled by an identical comparator stage, and the stages are chained from the least significant slice upward.

Every stage takes a three-wire result from the stage below it. When the stage's own two slices differ, its own comparison sets the result and the lower result is ignored. When the slices match, the stage passes the lower result through unchanged. The top module brings out the cascade inputs of the lowest stage. Tie them to "equal" (eq high, lt and gt low) for a plain compare, or drive them from another comparator's result to widen the compare further.

The block is purely combinational. It has no clock and no reset.

Top module: `mag_cmp_chain`

## Requirements
- R1: With the cascade inputs at lt_in=0, eq_in=1, gt_in=0, the outputs give the unsigned ordering of a_i and b_i: lt_o when a_i<b_i, eq_o when a_i==b_i, gt_o when a_i>b_i.
- R2: Whenever exactly one cascade input is high, exactly one of lt_o, eq_o, gt_o is high.
- R3: When a_i equals b_i, lt_o, eq_o and gt_o copy lt_in, eq_in and gt_in in that order, for any pattern on those inputs (including none high or two high).
- R4: When a_i differs from b_i, the cascade inputs have no effect on the outputs.
- R5: A difference in a more significant 4-bit slice decides the result, whatever the less significant slices hold.
- R6: Inside a slice, the highest differing bit decides the result (for example 4'b1000 is above 4'b0111).
- R7: The operand width is STAGES*SLICE_W (12 bits by default), and bit 11 is the most significant bit of both operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | STAGES*SLICE_W | First unsigned operand |
| b_i | input | STAGES*SLICE_W | Second unsigned operand |
| lt_in | input | 1 | Cascade "below" result from a lower-order comparator |
| eq_in | input | 1 | Cascade "equal" result; tie high when nothing is below |
| gt_in | input | 1 | Cascade "above" result from a lower-order comparator |
| lt_o | output | 1 | High when a_i is below b_i, or the operands are equal and lt_in is high |
| eq_o | output | 1 | High when the operands are equal and eq_in is high |
| gt_o | output | 1 | High when a_i is above b_i, or the operands are equal and gt_in is high |

## Verification
The test cases cover four situations.

- **Equal operands:** all zeros, all ones, and a mixed pattern. Each is tried with every useful cascade pattern, which shows that the outputs pass the cascade inputs through.
- **Narrow differences:** operands that differ only in the least significant bit, or only in bit 11. These show that a change at either end of the 12-bit range is seen.
- **Competing slices:** pairs where an upper slice and a lower slice point in opposite directions, and pairs such as 1000 against 0111 inside one slice. These separate a correct most-significant-first decision from a wrong combination of the slices or bits.
- **Random vectors:** about a quarter are forced equal and some differ only in the least significant bit. They are run with random one-hot cascade inputs against a behavioural integer compare.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Three-wire ordering result passed between stages.
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } verdict_t;

  // The stage's own verdict wins unless its slices match; then the lower
  // stage's verdict passes through untouched.
  function automatic verdict_t merge_verdict(input verdict_t own_v,
                                             input verdict_t lower_v);
    verdict_t res;
    if (own_v.eq) res = lower_v;
    else          res = own_v;
    return res;
  endfunction

  // Result a plain compare starts from: "equal so far".
  function automatic verdict_t neutral_verdict();
    verdict_t res;
    res.lt = 1'b0;
    res.eq = 1'b1;
    res.gt = 1'b0;
    return res;
  endfunction

endpackage

// File: rtl/cmp_slice_order.sv
module cmp_slice_order
  import cmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  output verdict_t           v_o
);

  // same_above[i]: all bits at positions >= i match.
  logic [SLICE_W:0]   same_above;
  logic [SLICE_W-1:0] gt_hit;
  logic [SLICE_W-1:0] lt_hit;

  assign same_above[SLICE_W] = 1'b1;

  genvar i;
  generate
    for (i = SLICE_W - 1; i >= 0; i--) begin : g_bit
      assign same_above[i] = same_above[i+1] & ~(a_i[i] ^ b_i[i]);
      assign gt_hit[i]     = same_above[i+1] & a_i[i] & ~b_i[i];
      assign lt_hit[i]     = same_above[i+1] & ~a_i[i] & b_i[i];
    end
  endgenerate

  assign v_o.gt = |gt_hit;
  assign v_o.lt = |lt_hit;
  assign v_o.eq = same_above[0];

  always_comb begin
    AST_SLICE_MSB_DECIDES: assert ((v_o.gt == (a_i > b_i)) && (v_o.lt == (a_i < b_i))
                                   && (v_o.eq == (a_i == b_i))); // R6
  end

endmodule

// File: rtl/cmp_cascade_merge.sv
module cmp_cascade_merge
  import cmp_pkg::*;
(
  input  verdict_t own_i,
  input  verdict_t lower_i,
  output verdict_t v_o
);

  assign v_o = merge_verdict(own_i, lower_i);

  always_comb begin
    if (!own_i.eq) begin
      AST_DIFF_IGNORES_CASCADE: assert (v_o == own_i); // R4
    end
    if (own_i.eq) begin
      AST_EQ_COPIES_CASCADE: assert (v_o == lower_i); // R3
    end
    if ($onehot(lower_i) && $onehot(own_i)) begin
      AST_ONE_VERDICT: assert ($countones(v_o) == 1); // R2
    end
  end

endmodule

// File: rtl/cmp_stage.sv
module cmp_stage
  import cmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  verdict_t           lower_i,
  output verdict_t           v_o
);

  verdict_t own_v;

  cmp_slice_order #(.SLICE_W(SLICE_W)) u_order (
    .a_i (a_i),
    .b_i (b_i),
    .v_o (own_v)
  );

  cmp_cascade_merge u_merge (
    .own_i   (own_v),
    .lower_i (lower_i),
    .v_o     (v_o)
  );

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import cmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int STAGES  = 3,
  localparam int WIDTH  = SLICE_W * STAGES
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             lt_in,
  input  logic             eq_in,
  input  logic             gt_in,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o
);

  // link[k] enters stage k; link[STAGES] leaves the top stage.
  verdict_t link [STAGES+1];

  assign link[0].lt = lt_in;
  assign link[0].eq = eq_in;
  assign link[0].gt = gt_in;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      cmp_stage #(.SLICE_W(SLICE_W)) u_stage (
        .a_i     (a_i[k*SLICE_W +: SLICE_W]),
        .b_i     (b_i[k*SLICE_W +: SLICE_W]),
        .lower_i (link[k]),
        .v_o     (link[k+1])
      );
    end
  endgenerate

  assign lt_o = link[STAGES].lt;
  assign eq_o = link[STAGES].eq;
  assign gt_o = link[STAGES].gt;

endmodule

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b;
  logic ci_lt, ci_eq, ci_gt;
  logic lt, eq, gt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mag_cmp_chain u_mag_cmp_chain (
    .a_i (a), .b_i (b),
    .lt_in (ci_lt), .eq_in (ci_eq), .gt_in (ci_gt),
    .lt_o (lt), .eq_o (eq), .gt_o (gt)
  );

  // Behavioural reference: integer ordering, cascade only on a tie.
  task automatic run_vec(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic cl, input logic ce, input logic cg,
                         input string tag);
    int ia, ib;
    logic [2:0] exp_v;
    @(posedge clk);
    a = av; b = bv; ci_lt = cl; ci_eq = ce; ci_gt = cg;
    ia = int'(av);
    ib = int'(bv);
    if (ia < ib)      exp_v = 3'b100;
    else if (ia > ib) exp_v = 3'b001;
    else              exp_v = {cl, ce, cg};
    @(negedge clk);
    checks++;
    if ({lt, eq, gt} !== exp_v) begin
      errors++;
      $display("FAIL %s a=%h b=%h cas=%b%b%b got lt/eq/gt=%b expected %b",
               tag, av, bv, cl, ce, cg, {lt, eq, gt}, exp_v);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    a = '0; b = '0; ci_lt = 1'b0; ci_eq = 1'b1; ci_gt = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset/idle state: zero operands, neutral cascade gives "equal"
    run_vec(12'h000, 12'h000, 1'b0, 1'b1, 1'b0, "R1 idle state");
    run_vec(12'hFFF, 12'hFFF, 1'b0, 1'b1, 1'b0, "R1 all-ones equal");
    // LSB-only and MSB-only differences
    run_vec(12'h800, 12'h801, 1'b0, 1'b1, 1'b0, "R1 lsb-only below");
    run_vec(12'h801, 12'h800, 1'b0, 1'b1, 1'b0, "R1 lsb-only above");
    run_vec(12'h800, 12'h000, 1'b0, 1'b1, 1'b0, "R7 bit11 above");
    run_vec(12'h7FF, 12'h800, 1'b0, 1'b1, 1'b0, "R7 bit11 below");
    // Upper slice overrides lower slices
    run_vec(12'h120, 12'h11F, 1'b0, 1'b1, 1'b0, "R5 middle slice wins");
    run_vec(12'h0F0, 12'h100, 1'b0, 1'b1, 1'b0, "R5 top slice wins");
    run_vec(12'hA00, 12'h9FF, 1'b0, 1'b1, 1'b0, "R5 top slice above");
    // Highest differing bit within a slice
    run_vec(12'h008, 12'h007, 1'b0, 1'b1, 1'b0, "R6 1000 vs 0111");
    run_vec(12'h070, 12'h080, 1'b0, 1'b1, 1'b0, "R6 0111 vs 1000");
    run_vec(12'h005, 12'h006, 1'b0, 1'b1, 1'b0, "R6 0101 vs 0110");
    // Equal operands pass the cascade through
    run_vec(12'h5A5, 12'h5A5, 1'b1, 1'b0, 1'b0, "R3 equal copies lt");
    run_vec(12'h5A5, 12'h5A5, 1'b0, 1'b0, 1'b1, "R3 equal copies gt");
    run_vec(12'h000, 12'h000, 1'b0, 1'b0, 1'b0, "R3 equal copies none");
    run_vec(12'hFFF, 12'hFFF, 1'b1, 1'b0, 1'b1, "R3 equal copies two");
    // Differing operands ignore the cascade
    run_vec(12'h3C0, 12'h3C1, 1'b0, 1'b0, 1'b1, "R4 below ignores gt_in");
    run_vec(12'h300, 12'h2FF, 1'b1, 1'b0, 1'b0, "R4 above ignores lt_in");
    run_vec(12'h001, 12'h000, 1'b0, 1'b0, 1'b0, "R4 above ignores empty");
    run_vec(12'h000, 12'hFFF, 1'b1, 1'b1, 1'b1, "R4 below ignores all");

    // Random vectors, neutral cascade
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      case ($urandom_range(0, 3))
        0:       rb = ra;
        1:       rb = ra ^ 12'h001;
        default: rb = W'($urandom);
      endcase
      run_vec(ra, rb, 1'b0, 1'b1, 1'b0, "R1 random");
    end

    // Random vectors, random one-hot cascade
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] ra, rb;
      logic [2:0] oh;
      ra = W'($urandom);
      rb = ($urandom_range(0, 1) == 0) ? ra : W'($urandom);
      oh = 3'b001 << $urandom_range(0, 2);
      run_vec(ra, rb, oh[2], oh[1], oh[0], "R2 random one-hot");
      checks++;
      if ($countones({lt, eq, gt}) != 1) begin
        errors++;
        $display("FAIL R2 a=%h b=%h got %0d outputs high expected 1",
                 ra, rb, $countones({lt, eq, gt}));
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule